// File: doc/BRIEF.md
# Delayed-Update Filtered-Reference Adaptive Noise Canceller

This core performs single-channel active noise control. In each sample period it accepts one reference sample `x_in`, which is the noise picked up near its source, and one residual sample `e_in` from the error microphone. For every such sample it returns one anti-noise sample `y_out`. An adaptive FIR controller of `N` taps produces the anti-noise. Its weights follow a least-mean-square rule. That rule does not use the raw reference. It uses the reference after it has passed through a fixed `Q`-tap model of the acoustic path from loudspeaker to microphone.

The weight update uses the residual sample that arrived one sample earlier, together with the filtered-reference vector of that same earlier sample. Because of this fixed one-sample adaptation delay, two things can happen in the same clock cycle. Stage 1 adapts the weights and extends the delay lines. Stage 2 forms the FIR output. The adaptation delay is exactly one sample and is never deeper. The step size is a power of two, set by an arithmetic right shift of `SHIFT` bits.

Software loads the path model through a small write port. Writes are only accepted while adaptation is switched off. Samples, weights and coefficients are 16-bit signed fractions with 15 fraction bits. Products are summed at full width and then saturated back to 16 bits. The configuration must satisfy `N >= Q >= 2` and `N >= 2`.

Top module: `anc_dfxlms_core`

## Requirements
- R1: A synchronous active-high `rst` clears the weights, both delay lines, the stored residual, the path coefficients, `y_out` and `out_valid` to zero. As a result, the first weight update after reset uses a zero residual and leaves every weight unchanged.
- R2: For a sample accepted with `in_valid` high at a clock edge, `out_valid` is high for one cycle after the following edge. This is two cycles after the strobe. `out_valid` is never high unless such a sample exists.
- R3: The output for sample n is `y(n) = sat16((sum over i of w_i * x(n-i)) >>> 15)` for i from 0 to N-1. Here w is the weight set after the update made at sample n.
- R4: The filtered reference is `f(n) = sat16((sum over j of s_j * x(n-j)) >>> 15)` for j from 0 to Q-1, where `s_j` is the path coefficient at address j.
- R5: At sample n with `adapt_en` high, each weight becomes `w_i = sat16(w_i + ((e(n-1) * f(n-1-i)) >>> (15+SHIFT)))`. The adaptation delay is exactly one sample.
- R6: While `adapt_en` is low, accepted samples leave the weights unchanged. The delay lines and the stored residual still advance.
- R7: With `cfg_we` high and `adapt_en` low, `cfg_data` is written to coefficient `cfg_addr`. With `adapt_en` high, a write has no effect.
- R8: In a cycle with `in_valid` low, `x_in` and `e_in` are ignored and no internal state or output changes.
- R9: `y_out`, the filtered reference and every weight saturate to the range -32768 to 32767 instead of wrapping.
- R10: Samples may be presented on consecutive cycles. The output of sample n and the weight update of sample n+1 then occur at the same edge, and each still follows R3 and R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| adapt_en | input | 1 | Enables weight adaptation and locks out coefficient writes |
| cfg_we | input | 1 | Path coefficient write strobe |
| cfg_addr | input | clog2(Q) | Path coefficient index |
| cfg_data | input | 16 | Path coefficient value (signed, 15 fraction bits) |
| in_valid | input | 1 | A new reference/residual sample pair is present |
| x_in | input | 16 | Reference sample (signed) |
| e_in | input | 16 | Residual microphone sample (signed) |
| out_valid | output | 1 | `y_out` carries a new anti-noise sample |
| y_out | output | 16 | Anti-noise sample (signed, saturated) |

## Verification
Two operations can collide in the same edge when samples arrive on back-to-back cycles: the output stage forms y(n) from the weights, and the adaptation stage rewrites those weights for sample n+1. The bench provokes this collision with long runs of consecutive strobes, with widely varying and with saturating inputs. It then compares each anti-noise sample bit-exactly, and in its exact cycle, with a model that produces y(n) from the weights as they stood right after update n. Runs separated by idle cycles, runs with adaptation switched off, and writes that are locked out each test a different ordering against the same model.

// File: rtl/anc_pkg.sv
`timescale 1ns/1ps
package anc_pkg;
    localparam int DW   = 16;          // sample, weight and coefficient width
    localparam int FRAC = DW - 1;      // fraction bits
    localparam int ACCW = 2*DW + 8;    // accumulator: product plus headroom for up to 256 taps

    typedef logic signed [DW-1:0]   smp_t;
    typedef logic signed [ACCW-1:0] acc_t;

    localparam acc_t SMAX = acc_t'((1 << (DW-1)) - 1);
    localparam acc_t SMIN = -SMAX - acc_t'(1);

    function automatic smp_t sat_smp(input acc_t v);
        if (v > SMAX) return smp_t'(SMAX);
        if (v < SMIN) return smp_t'(SMIN);
        return smp_t'(v);
    endfunction

    function automatic acc_t mul_ext(input smp_t a, input smp_t b);
        return acc_t'(a) * acc_t'(b);
    endfunction
endpackage

// File: rtl/anc_pathmodel.sv
`timescale 1ns/1ps
module anc_pathmodel import anc_pkg::*; #(
    parameter int Q   = 4,
    parameter int QAW = (Q > 1) ? $clog2(Q) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            adapt_en,
    input  logic            cfg_we,
    input  logic [QAW-1:0]  cfg_addr,
    input  smp_t            cfg_data,
    input  smp_t [Q-1:0]    x_vec,      // x(n) at index 0, older samples above
    output smp_t            xf_now
);
    smp_t [Q-1:0] coef_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            coef_q <= '0;
        end else if (cfg_we && !adapt_en && (int'(cfg_addr) < Q)) begin
            coef_q[cfg_addr] <= cfg_data;
        end
    end

    always_comb begin
        acc_t acc;
        acc = '0;
        for (int j = 0; j < Q; j++) begin
            acc = acc + mul_ext(coef_q[j], x_vec[j]);
        end
        xf_now = sat_smp(acc >>> FRAC);
    end

    AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (rst)
        adapt_en |=> $stable(coef_q));                               // R7
    AST_CFG_WRITE0: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && !adapt_en && cfg_addr == '0) |=> coef_q[0] == $past(cfg_data)); // R7
endmodule

// File: rtl/anc_adapt.sv
`timescale 1ns/1ps
module anc_adapt import anc_pkg::*; #(
    parameter int N     = 8,
    parameter int SHIFT = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          adapt_en,
    input  logic          in_valid,
    input  smp_t          e_in,
    input  smp_t          xf_now,
    output smp_t [N-1:0]  w_vec
);
    localparam int STEP_SH = FRAC + SHIFT;

    smp_t [N-1:0] w_q;
    smp_t [N-1:0] w_next;
    smp_t [N-1:0] xf_line;   // filtered reference, newest at index 0
    smp_t         e_dly;     // residual of the previous sample

    always_comb begin
        for (int i = 0; i < N; i++) begin
            acc_t step;
            step      = mul_ext(e_dly, xf_line[i]) >>> STEP_SH;
            w_next[i] = sat_smp(acc_t'($signed(w_q[i])) + step);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            w_q     <= '0;
            xf_line <= '0;
            e_dly   <= '0;
        end else if (in_valid) begin
            if (adapt_en) w_q <= w_next;
            xf_line <= {xf_line[N-2:0], xf_now};
            e_dly   <= e_in;
        end
    end

    assign w_vec = w_q;

    AST_HOLD_WEIGHTS: assert property (@(posedge clk) disable iff (rst)
        !(in_valid && adapt_en) |=> $stable(w_q));                  // R6
    AST_ZERO_ERR_NO_STEP: assert property (@(posedge clk) disable iff (rst)
        (in_valid && e_dly == '0) |=> $stable(w_q));                 // R1
    AST_ERR_ONE_LATE: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> e_dly == $past(e_in));                          // R5
    AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(xf_line) && $stable(e_dly)));         // R8
endmodule

// File: rtl/anc_outstage.sv
`timescale 1ns/1ps
module anc_outstage import anc_pkg::*; #(
    parameter int N = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          vld_s1,
    input  smp_t [N-1:0]  w_vec,
    input  smp_t [N-1:0]  x_line,
    output logic          out_valid,
    output smp_t          y_out
);
    smp_t y_next;

    always_comb begin
        acc_t acc;
        acc = '0;
        for (int i = 0; i < N; i++) begin
            acc = acc + mul_ext(w_vec[i], x_line[i]);
        end
        y_next = sat_smp(acc >>> FRAC);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            y_out     <= '0;
        end else begin
            out_valid <= vld_s1;
            if (vld_s1) y_out <= y_next;
        end
    end

    AST_Y_HELD: assert property (@(posedge clk) disable iff (rst)
        !vld_s1 |=> $stable(y_out));                                 // R8
endmodule

// File: rtl/anc_dfxlms_core.sv
`timescale 1ns/1ps
module anc_dfxlms_core import anc_pkg::*; #(
    parameter int N     = 8,
    parameter int Q     = 4,
    parameter int SHIFT = 6,
    localparam int QAW  = (Q > 1) ? $clog2(Q) : 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    adapt_en,
    input  logic                    cfg_we,
    input  logic [QAW-1:0]          cfg_addr,
    input  logic signed [DW-1:0]    cfg_data,
    input  logic                    in_valid,
    input  logic signed [DW-1:0]    x_in,
    input  logic signed [DW-1:0]    e_in,
    output logic                    out_valid,
    output logic signed [DW-1:0]    y_out
);
    smp_t [N-1:0] x_line;    // reference history, x(n) at index 0 after capture
    smp_t [Q-1:0] x_vec;     // x(n) .. x(n-Q+1) seen by the path model
    smp_t [N-1:0] w_vec;
    smp_t         xf_now;
    smp_t         y_q;
    logic         vld_s1;

    // stage 1 bookkeeping shared by both stages
    always_ff @(posedge clk) begin
        if (rst) begin
            x_line <= '0;
            vld_s1 <= 1'b0;
        end else begin
            vld_s1 <= in_valid;
            if (in_valid) x_line <= {x_line[N-2:0], smp_t'(x_in)};
        end
    end

    always_comb x_vec[0] = x_in;
    for (genvar j = 1; j < Q; j++) begin : g_xvec
        always_comb x_vec[j] = x_line[j-1];
    end

    anc_pathmodel #(.Q(Q), .QAW(QAW)) u_path (
        .clk(clk), .rst(rst), .adapt_en(adapt_en),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
        .x_vec(x_vec), .xf_now(xf_now)
    );

    anc_adapt #(.N(N), .SHIFT(SHIFT)) u_adapt (
        .clk(clk), .rst(rst), .adapt_en(adapt_en), .in_valid(in_valid),
        .e_in(e_in), .xf_now(xf_now), .w_vec(w_vec)
    );

    anc_outstage #(.N(N)) u_out (
        .clk(clk), .rst(rst), .vld_s1(vld_s1), .w_vec(w_vec),
        .x_line(x_line), .out_valid(out_valid), .y_out(y_q)
    );

    assign y_out = y_q;

    AST_TWO_CYCLE: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> ##2 out_valid);                                  // R2
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(vld_s1));                                 // R2
    AST_WEIGHT_VS_OUTPUT: assert property (@(posedge clk) disable iff (rst)
        (vld_s1 && $stable(w_vec) && $stable(x_line)) |=> $stable(y_out)); // R10
endmodule

// File: tb/sim_anc_dfxlms_core.sv
`timescale 1ns/1ps
module sim_anc_dfxlms_core;
    localparam int NT = 8;
    localparam int QT = 4;
    localparam int SH = 6;
    localparam int LIMIT = 20000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic adapt_en = 1'b0;
    logic cfg_we = 1'b0;
    logic [1:0] cfg_addr = '0;
    logic signed [15:0] cfg_data = '0;
    logic in_valid = 1'b0;
    logic signed [15:0] x_in = '0;
    logic signed [15:0] e_in = '0;
    logic out_valid;
    logic signed [15:0] y_out;

    anc_dfxlms_core #(.N(NT), .Q(QT), .SHIFT(SH)) u0 (
        .clk(clk), .rst(rst), .adapt_en(adapt_en), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_data(cfg_data), .in_valid(in_valid),
        .x_in(x_in), .e_in(e_in), .out_valid(out_valid), .y_out(y_out)
    );

    always #10 clk = ~clk;   // 50 MHz

    typedef struct { int y; int due; string tag; } exp_t;
    exp_t q[$];

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 0;
    bit tmo    = 0;

    // model state
    int mw[NT];
    int mxl[NT];
    int mxf[NT];
    int mcoef[QT];
    int med;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > LIMIT) tmo <= 1'b1;
    end

    function automatic int sat(input longint v);
        if (v > 32767)  return 32767;
        if (v < -32768) return -32768;
        return int'(v);
    endfunction

    task automatic check(input bit ok, input string tg, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tg, act, expv, cyc);
        end
    endtask

    task automatic send(input int xv, input int ev, input bit ad, input string tg);
        longint acc;
        int xcur[QT];
        int xfv;
        exp_t it;
        @(negedge clk);
        cfg_we = 1'b0; in_valid = 1'b1; x_in = 16'(xv); e_in = 16'(ev); adapt_en = ad;
        xcur[0] = xv;
        for (int j = 1; j < QT; j++) xcur[j] = mxl[j-1];
        acc = 0;
        for (int j = 0; j < QT; j++) acc += longint'(mcoef[j]) * xcur[j];
        xfv = sat(acc >>> 15);
        if (ad) for (int i = 0; i < NT; i++)
            mw[i] = sat(longint'(mw[i]) + ((longint'(med) * mxf[i]) >>> (15 + SH)));
        for (int i = NT-1; i > 0; i--) begin mxl[i] = mxl[i-1]; mxf[i] = mxf[i-1]; end
        mxl[0] = xv; mxf[0] = xfv; med = ev;
        acc = 0;
        for (int i = 0; i < NT; i++) acc += longint'(mw[i]) * mxl[i];
        it.y = sat(acc >>> 15); it.due = cyc + 2; it.tag = tg;
        q.push_back(it);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            cfg_we = 1'b0; in_valid = 1'b0; x_in = 16'sd12345; e_in = -16'sd23456;
        end
    endtask

    task automatic cfg(input int a, input int d, input bit ad);
        @(negedge clk);
        in_valid = 1'b0; cfg_we = 1'b1; cfg_addr = 2'(a); cfg_data = 16'(d); adapt_en = ad;
        if (!ad) mcoef[a] = d;   // R7: locked-out writes leave the model unchanged
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (q.size() == 0) begin
                check(1'b0, "R2 unexpected out_valid", 1, 0);
            end else begin
                exp_t it;
                it = q.pop_front();
                check(int'(y_out) == it.y, it.tag, int'(y_out), it.y);
                check(cyc == it.due, "R2 latency", cyc, it.due);
            end
        end
    end

    initial begin
        for (int i = 0; i < NT; i++) begin mw[i] = 0; mxl[i] = 0; mxf[i] = 0; end
        for (int j = 0; j < QT; j++) mcoef[j] = 0;
        med = 0;
        repeat (4) @(negedge clk);
        check(out_valid == 1'b0, "R1 reset out_valid", int'(out_valid), 0);
        check(y_out == 16'sd0, "R1 reset y_out", int'(y_out), 0);
        rst = 1'b0;

        // R7 path model load, then a locked-out write
        cfg(0, 16384, 1'b0);
        cfg(1, 8192, 1'b0);
        cfg(2, -4096, 1'b0);
        cfg(3, 2048, 1'b0);
        cfg(1, -30000, 1'b1);
        idle(1);

        // R1 first updates after reset see zero residual
        send(20000, 30000, 1'b1, "R1");
        send(-15000, 25000, 1'b1, "R1");

        // R10 back-to-back, R4/R5 adaptation with varied data
        for (int k = 0; k < 40; k++)
            send(((k * 7919) % 40000) - 20000, ((k * 104729) % 50000) - 25000, 1'b1, "R10/R3/R4/R5");

        // R8 gapped samples with junk between them
        for (int k = 0; k < 20; k++) begin
            send(((k * 3571) % 30000) - 15000, ((k * 611) % 20000) - 10000, 1'b1, "R8/R3");
            idle(2);
        end

        // R6 adaptation off, with an accepted coefficient change (R7)
        cfg(2, 6000, 1'b0);
        for (int k = 0; k < 20; k++)
            send(((k * 911) % 32000) - 16000, 30000, 1'b0, "R6/R7");

        // R9 saturation of weights and output
        for (int k = 0; k < 100; k++) send(32000, 32000, 1'b1, "R9 pos");
        for (int k = 0; k < 10; k++)  send(-32000, 0, 1'b1, "R9 neg");
        idle(4);
        check(q.size() == 0, "R2 pending outputs", q.size(), 0);
        done = 1'b1;
    end

    initial begin
        wait (done || tmo);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual %0d expected done before %0d", cyc, LIMIT);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule